// File: doc/BRIEF.md
# Board Reset Sequencer with Debug-Port Mapping

This block produces every reset line of a processor board from a few supply and request inputs: a power-good level, a standby-supply-stable flag, a reset-switch input, a short self-reset request from the processor, and three reset requests from a debug connector together with a debugger-attached flag. All inputs are asynchronous to the sequencer clock. Each one passes through a two-flop synchroniser before any logic uses it. Every output is a registered active-low reset.

A full system reset is held while the standby supply is unstable, while power-good is low, while the switch is pressed, and for a stretched window after each processor request. When the hold ends, the processor power-on reset and the peripheral resets release together. The processor hard reset follows `HRST_DLY` clocks later, and the configuration-drive enable follows one clock after that. Debug requests are cross-mapped: the connector's hard request drives processor power-on reset, and its soft request drives processor hard reset. The processor test reset belongs to the debugger whenever one is attached. With no debugger attached, the sequencer asserts the test reset itself during a system hold.

Top module: `brd_rst_seq`

## Requirements
- R1: Holding `dbg_hard_n_i` low (debugger side, active-low) drives `cpu_por_n_o` low. It leaves `cpu_hrst_n_o` released when nothing else requests hard reset.
- R2: Holding `dbg_soft_n_i` low drives `cpu_hrst_n_o` low. It leaves `cpu_por_n_o` released when nothing else requests power-on reset.
- R3: With `dbg_present_i` high, `cpu_trst_n_o` equals `dbg_test_n_i` as long as `hot_ok_i` is high.
- R4: With `dbg_present_i` high, neither a debug hard request nor a system hold (power-good low, switch pressed, processor request) asserts `cpu_trst_n_o`.
- R5: With `dbg_present_i` low, `cpu_trst_n_o` is low exactly while the system hold is active, and `dbg_test_n_i` has no effect.
- R6: A processor request (`cpu_req_n_i` low for one clock) keeps the system hold for `STRETCH_LEN`+1 clocks of output. `cpu_por_n_o` then releases.
- R7: `pwr_good_i` low or `sw_rst_n_i` low holds `cpu_por_n_o`, `cpu_hrst_n_o`, `cfg_drv_n_o` and the three peripheral resets low.
- R8: `cfg_drv_n_o` stays low for exactly one clock after `cpu_hrst_n_o` rises, and then rises itself.
- R9: `hot_ok_i` low drives all seven outputs low, whether or not a debugger is attached.
- R10: `phy_rst_n_o`, `mem_rst_n_o` and `dev_rst_n_o` are low exactly during the system hold and release in the same clock as `cpu_por_n_o`.
- R11: After the hold ends, `cpu_por_n_o` rises on the third rising edge after the input change (two synchroniser stages plus the output register). `cpu_hrst_n_o` rises `HRST_DLY` clocks later.
- R12: The synchronous `rst` input drives all seven outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good_i | input | 1 | Main supply good, high when stable and no switch reset |
| hot_ok_i | input | 1 | Standby supply stable, high once settled |
| sw_rst_n_i | input | 1 | Reset switch, low while pressed |
| cpu_req_n_i | input | 1 | Processor self-reset request, low pulse |
| dbg_hard_n_i | input | 1 | Debug connector hard-reset request, active-low |
| dbg_soft_n_i | input | 1 | Debug connector soft-reset request, active-low |
| dbg_test_n_i | input | 1 | Debug connector test-reset request, active-low |
| dbg_present_i | input | 1 | High when a debugger is attached |
| cpu_por_n_o | output | 1 | Processor power-on reset, active-low |
| cpu_hrst_n_o | output | 1 | Processor hard reset, active-low |
| cpu_trst_n_o | output | 1 | Processor test-logic reset, active-low |
| cfg_drv_n_o | output | 1 | Configuration-drive enable, active-low |
| phy_rst_n_o | output | 1 | PHY soft reset, active-low |
| mem_rst_n_o | output | 1 | Memory module reset, active-low |
| dev_rst_n_o | output | 1 | General device reset, active-low |

## Verification
The assertions are written against the synchronised copies of the inputs. They rely on each input being a clean level that the synchronisers see for at least one clock, and on the debugger-attached flag staying constant while a debug request is evaluated. The stimulus changes inputs only on falling clock edges. It holds each combination of the seven level inputs for twenty clocks, well beyond the longest release sequence, before the steady outputs are compared. The timed cases then move one input at a time, so the expected edges follow directly from the three-register path and the two delay parameters.

// File: rtl/brd_rst_pkg.sv
package brd_rst_pkg;
  typedef enum logic [1:0] {
    SEQ_HOLD = 2'd0,
    SEQ_WAIT = 2'd1,
    SEQ_RUN  = 2'd2
  } seq_st_t;
endpackage

// File: rtl/rst_sync2.sv
module rst_sync2 #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= {2{RST_VAL[g]}};
      else     sh <= {sh[0], d[g]};
    end
    assign q[g] = sh[1];
  end
endmodule

// File: rtl/rst_req_stretch.sv
module rst_req_stretch #(
  parameter int STRETCH_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic active
);
  localparam int CW = $clog2(STRETCH_LEN + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (req)          cnt_q <= CW'(STRETCH_LEN);
    else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
  end

  assign active = req | (cnt_q != '0);

  AST_STRETCH_LOAD: assert property (@(posedge clk) disable iff (rst)
    req |=> (cnt_q == CW'(STRETCH_LEN))); // R6
  AST_STRETCH_COUNTDOWN: assert property (@(posedge clk) disable iff (rst)
    (!req && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1))); // R6
endmodule

// File: rtl/rst_release_ctl.sv
module rst_release_ctl
  import brd_rst_pkg::*;
#(
  parameter int HRST_DLY = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic sys_hold,
  output logic hold_nxt,
  output logic hrst_nxt
);
  localparam int CW = (HRST_DLY > 1) ? $clog2(HRST_DLY) : 1;

  seq_st_t       st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    if (sys_hold) begin
      st_n  = SEQ_HOLD;
      cnt_n = '0;
    end else begin
      case (st_q)
        SEQ_HOLD: begin
          st_n  = SEQ_WAIT;
          cnt_n = '0;
        end
        SEQ_WAIT: begin
          if (cnt_q == CW'(HRST_DLY - 1)) st_n = SEQ_RUN;
          else                            cnt_n = cnt_q + CW'(1);
        end
        SEQ_RUN:  st_n = SEQ_RUN;
        default:  st_n = SEQ_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= SEQ_HOLD;
      cnt_q <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
    end
  end

  assign hold_nxt = (st_n == SEQ_HOLD);
  assign hrst_nxt = (st_n == SEQ_HOLD) || (st_n == SEQ_WAIT);

  AST_HOLD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    sys_hold |=> (st_q == SEQ_HOLD)); // R7
  AST_WAIT_SPAN: assert property (@(posedge clk) disable iff (rst)
    (st_q == SEQ_RUN && $past(st_q) == SEQ_WAIT) |-> ($past(cnt_q) == CW'(HRST_DLY - 1))); // R11
endmodule

// File: rtl/brd_rst_seq.sv
module brd_rst_seq #(
  parameter int HRST_DLY    = 8,
  parameter int STRETCH_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_good_i,
  input  logic hot_ok_i,
  input  logic sw_rst_n_i,
  input  logic cpu_req_n_i,
  input  logic dbg_hard_n_i,
  input  logic dbg_soft_n_i,
  input  logic dbg_test_n_i,
  input  logic dbg_present_i,
  output logic cpu_por_n_o,
  output logic cpu_hrst_n_o,
  output logic cpu_trst_n_o,
  output logic cfg_drv_n_o,
  output logic phy_rst_n_o,
  output logic mem_rst_n_o,
  output logic dev_rst_n_o
);
  localparam int NIN = 8;
  localparam logic [NIN-1:0] IDLE_VAL = 8'b0011_1110;

  logic [NIN-1:0] raw, syn;
  logic pwr_s, hot_s, sw_s, req_s, hard_s, soft_s, test_s, dbg_on_s;
  logic stretch_on, sys_hold, hold_nxt, hrst_nxt;
  logic por_a, hrst_a, trst_a, cfg_a, per_a;

  assign raw = {pwr_good_i, hot_ok_i, sw_rst_n_i, cpu_req_n_i,
                dbg_hard_n_i, dbg_soft_n_i, dbg_test_n_i, dbg_present_i};

  rst_sync2 #(.W(NIN), .RST_VAL(IDLE_VAL)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(syn)
  );

  assign pwr_s    =  syn[7];
  assign hot_s    =  syn[6];
  assign sw_s     = ~syn[5];
  assign req_s    = ~syn[4];
  assign hard_s   = ~syn[3];
  assign soft_s   = ~syn[2];
  assign test_s   = ~syn[1];
  assign dbg_on_s =  syn[0];

  rst_req_stretch #(.STRETCH_LEN(STRETCH_LEN)) u_stretch (
    .clk(clk), .rst(rst), .req(req_s), .active(stretch_on)
  );

  assign sys_hold = ~hot_s | ~pwr_s | sw_s | stretch_on;

  rst_release_ctl #(.HRST_DLY(HRST_DLY)) u_ctl (
    .clk(clk), .rst(rst), .sys_hold(sys_hold),
    .hold_nxt(hold_nxt), .hrst_nxt(hrst_nxt)
  );

  assign por_a  = ~hot_s | hold_nxt | hard_s;
  assign hrst_a = ~hot_s | hrst_nxt | soft_s;
  assign cfg_a  = hrst_a | ~cpu_hrst_n_o;
  assign trst_a = ~hot_s | (dbg_on_s ? test_s : hold_nxt);
  assign per_a  = hold_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_por_n_o  <= 1'b0;
      cpu_hrst_n_o <= 1'b0;
      cpu_trst_n_o <= 1'b0;
      cfg_drv_n_o  <= 1'b0;
      phy_rst_n_o  <= 1'b0;
      mem_rst_n_o  <= 1'b0;
      dev_rst_n_o  <= 1'b0;
    end else begin
      cpu_por_n_o  <= ~por_a;
      cpu_hrst_n_o <= ~hrst_a;
      cpu_trst_n_o <= ~trst_a;
      cfg_drv_n_o  <= ~cfg_a;
      phy_rst_n_o  <= ~per_a;
      mem_rst_n_o  <= ~per_a;
      dev_rst_n_o  <= ~per_a;
    end
  end

  AST_HARD_TO_POR: assert property (@(posedge clk) disable iff (rst)
    hard_s |=> !cpu_por_n_o); // R1
  AST_SOFT_TO_HRST: assert property (@(posedge clk) disable iff (rst)
    soft_s |=> !cpu_hrst_n_o); // R2
  AST_TEST_TO_TRST: assert property (@(posedge clk) disable iff (rst)
    (hot_s && dbg_on_s && test_s) |=> !cpu_trst_n_o); // R3
  AST_TRST_DBG_OWNED: assert property (@(posedge clk) disable iff (rst)
    (hot_s && dbg_on_s && !test_s) |=> cpu_trst_n_o); // R4
  AST_CFG_TRAILS: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_hrst_n_o) |-> !cfg_drv_n_o); // R8
  AST_CFG_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
    (cpu_hrst_n_o && $past(cpu_hrst_n_o)) |-> cfg_drv_n_o); // R8
  AST_HOT_HOLDS_ALL: assert property (@(posedge clk) disable iff (rst)
    !hot_s |=> (!cpu_por_n_o && !cpu_hrst_n_o && !cpu_trst_n_o && !cfg_drv_n_o
                && !phy_rst_n_o && !mem_rst_n_o && !dev_rst_n_o)); // R9
  AST_PERIPH_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !phy_rst_n_o |-> !cpu_por_n_o); // R10
endmodule

// File: tb/sim_brd_rst_seq.sv
`timescale 1ns/1ps
module sim_brd_rst_seq;
  localparam int DLY = 4;
  localparam int STR = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr, hot, sw_n, req_n, hard_n, soft_n, test_n, pres;
  logic por_n, hrst_n, trst_n, cfg_n, phy_n, mem_n, dev_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  brd_rst_seq #(.HRST_DLY(DLY), .STRETCH_LEN(STR)) u0 (
    .clk(clk), .rst(rst),
    .pwr_good_i(pwr), .hot_ok_i(hot), .sw_rst_n_i(sw_n), .cpu_req_n_i(req_n),
    .dbg_hard_n_i(hard_n), .dbg_soft_n_i(soft_n), .dbg_test_n_i(test_n),
    .dbg_present_i(pres),
    .cpu_por_n_o(por_n), .cpu_hrst_n_o(hrst_n), .cpu_trst_n_o(trst_n),
    .cfg_drv_n_o(cfg_n), .phy_rst_n_o(phy_n), .mem_rst_n_o(mem_n),
    .dev_rst_n_o(dev_n)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    pwr = 1; hot = 1; sw_n = 1; req_n = 1;
    hard_n = 1; soft_n = 1; test_n = 1; pres = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    @(negedge clk);
    step(3);
    // R12: reset state
    chk("R12 por",  por_n,  1'b0);
    chk("R12 hrst", hrst_n, 1'b0);
    chk("R12 trst", trst_n, 1'b0);
    chk("R12 cfg",  cfg_n,  1'b0);
    chk("R12 phy",  phy_n,  1'b0);
    chk("R12 mem",  mem_n,  1'b0);
    chk("R12 dev",  dev_n,  1'b0);
    rst = 1'b0;
    step(20);

    // Exhaustive sweep of the seven level inputs (R1 R2 R3 R4 R5 R7 R9 R10)
    for (int v = 0; v < 128; v++) begin
      logic sysh, e_por, e_hrst, e_trst;
      {pwr, hot, sw_n, hard_n, soft_n, test_n, pres} = 7'(v);
      step(20);
      sysh   = !hot || !pwr || !sw_n;
      e_por  = sysh || !hard_n;
      e_hrst = sysh || !soft_n;
      e_trst = !hot || (pres ? !test_n : sysh);
      chk(hot ? "R1 R7 por" : "R9 por", por_n, !e_por);
      chk(hot ? "R2 R7 hrst" : "R9 hrst", hrst_n, !e_hrst);
      chk(hot ? (pres ? "R3 R4 trst" : "R5 trst") : "R9 trst", trst_n, !e_trst);
      chk(hot ? "R7 R8 cfg" : "R9 cfg", cfg_n, !e_hrst);
      chk("R10 phy", phy_n, !sysh);
      chk("R10 mem", mem_n, !sysh);
      chk("R10 dev", dev_n, !sysh);
    end

    // R11 R8 R10: release order after power-good rises
    idle_inputs();
    pwr = 0;
    step(20);
    pwr = 1;
    step(2);
    chk("R11 por held", por_n, 1'b0);
    step(1);
    chk("R11 por release", por_n, 1'b1);
    chk("R10 mem release", mem_n, 1'b1);
    chk("R11 hrst held", hrst_n, 1'b0);
    step(DLY - 1);
    chk("R11 hrst still held", hrst_n, 1'b0);
    step(1);
    chk("R11 hrst release", hrst_n, 1'b1);
    chk("R8 cfg one more", cfg_n, 1'b0);
    step(1);
    chk("R8 cfg release", cfg_n, 1'b1);

    // R6: single-clock processor request is stretched
    step(10);
    req_n = 0;
    step(1);
    req_n = 1;
    step(2);
    chk("R6 por asserted", por_n, 1'b0);
    chk("R5 trst in hold", trst_n, 1'b0);
    step(STR);
    chk("R6 por still held", por_n, 1'b0);
    chk("R6 phy still held", phy_n, 1'b0);
    step(1);
    chk("R6 por released", por_n, 1'b1);
    chk("R6 hrst held", hrst_n, 1'b0);
    step(DLY - 1);
    chk("R6 hrst held end", hrst_n, 1'b0);
    step(1);
    chk("R6 hrst released", hrst_n, 1'b1);
    chk("R8 cfg trails", cfg_n, 1'b0);
    step(1);
    chk("R8 cfg released", cfg_n, 1'b1);

    // R8 R2: cfg trails a debug soft reset release by one clock
    pres = 1;
    soft_n = 0;
    step(10);
    chk("R2 hrst by soft", hrst_n, 1'b0);
    chk("R2 por untouched", por_n, 1'b1);
    soft_n = 1;
    step(3);
    chk("R2 hrst release", hrst_n, 1'b1);
    chk("R8 cfg after soft", cfg_n, 1'b0);
    step(1);
    chk("R8 cfg after soft release", cfg_n, 1'b1);
    chk("R4 trst free", trst_n, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule